// File: doc/BRIEF.md
# Byte Sign-Extend Execution Unit

This unit recognises one instruction, "take a byte lane from a register and sign-extend it", in three bit-exact forms. One form is a 32-bit word from the fixed-width instruction set. The other two come from the compact instruction set: a 16-bit halfword and a 32-bit pair of halfwords. The unit turns the selected source register index into a register-file read address. It rotates the returned value right by 0, 8, 16 or 24 bits, keeps the low byte and sign-extends that byte to 32 bits.

Decode and the datapath are purely combinational, and the rotation is a fixed byte-lane mux. Every result therefore takes the same time whatever the operand value is. One register stage presents the match flag, the unpredictable flag, the destination index, the write enable and the result together, one clock after the inputs are sampled. An encoding that names register 15, or that has a nonzero should-be-zero bit, still matches. It raises the unpredictable flag, and the write is dropped. A failed condition also drops the write but leaves the match flag set.

Top module: `byte_sext_unit`

## Requirements
- R1: With `mode_i`=0, a word matches when all of these hold: bits [31:28] are not 4'hF, bits [27:20] are 8'h6A, bits [19:16] are 4'hF and bits [7:4] are 4'h7. The destination is bits [15:12], the source is bits [3:0], the rotate field is bits [11:10] and the should-be-zero field is bits [9:8].
- R2: With `mode_i`=1 and bits [31:16] not 16'hFA4F, the short form matches when bits [15:6] are 10'b1011001001. The source is bits [5:3] and the destination is bits [2:0], both zero-extended to 4 bits. The rotation is zero, and this form never raises the unpredictable flag.
- R3: With `mode_i`=1 and bits [31:16] equal to 16'hFA4F, the long form matches when bits [15:12] are 4'hF and bit 7 is 1. The destination is bits [11:8], the rotate field is bits [5:4], bit 6 is should-be-zero and the source is bits [3:0].
- R4: The result is bits [7:0] of the source value rotated right by 8 times the rotate field, sign-extended from bit 7 to 32 bits.
- R5: In both 32-bit forms, a destination or source of 15 sets the unpredictable flag and clears the write enable. Register 13 is legal and raises no flag.
- R6: A nonzero should-be-zero bit (bits [9:8] in the fixed form, bit 6 in the long compact form) still matches, but sets the unpredictable flag and clears the write enable.
- R7: When `cond_pass_i` is low, the write enable is low and the match flag still reports the decode.
- R8: All five outputs change exactly one clock after the inputs are sampled, whatever the operand data is. Back-to-back instructions give back-to-back results.
- R9: While `rst_ni` is low, every output is zero.
- R10: A word that fits no form gives match, unpredictable and write enable all low.
- R11: The mode select is exclusive. A fixed-form word in compact mode does not match, and a short-form halfword in fixed mode does not match. A long-form prefix whose second halfword is malformed does not fall back to the short form and does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0: fixed-width decode, 1: compact decode |
| instr_i | input | 32 | Instruction; short compact form in [15:0], long compact form with first halfword in [31:16] |
| cond_pass_i | input | 1 | Condition-pass result from outside |
| rs_addr_o | output | 4 | Register-file read address (decoded source) |
| rs_data_i | input | 32 | Register-file read data |
| match_o | output | 1 | Instruction decoded as one of the three forms |
| unpred_o | output | 1 | Decoded encoding is unpredictable |
| rd_o | output | 4 | Destination register index |
| we_o | output | 1 | Register write enable |
| result_o | output | 32 | Sign-extended byte result |

## Verification
Write suppression has two independent sources, the unpredictable check and the condition-pass input, and both can act in the same cycle. The bench provokes this with a fixed-form word whose destination is 15 while `cond_pass_i` is low. It expects match and unpredictable high and the write enable low. Each source is also driven alone, so that a design which merges or drops one of them shows up as a wrong flag.

// File: rtl/bsx_pkg.sv
`timescale 1ns/1ps
package bsx_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = XLEN / LANE_W;
  localparam int unsigned ROT_W  = $clog2(LANES);
  localparam int unsigned REG_W  = 4;
  localparam logic [REG_W-1:0] PC_REG = '1;

  typedef struct packed {
    logic             hit;
    logic             unpred;
    logic [REG_W-1:0] rd;
    logic [REG_W-1:0] rm;
    logic [ROT_W-1:0] rot;
  } dec_t;
endpackage

// File: rtl/bsx_dec_wide.sv
`timescale 1ns/1ps
module bsx_dec_wide
  import bsx_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic hit;
  logic sbz_bad;

  assign hit = (instr_i[31:28] != 4'hF) && (instr_i[27:20] == 8'h6A) &&
               (instr_i[19:16] == 4'hF) && (instr_i[7:4] == 4'h7);
  assign sbz_bad = |instr_i[9:8];

  always_comb begin
    dec_o.hit    = hit;
    dec_o.rd     = instr_i[15:12];
    dec_o.rm     = instr_i[3:0];
    dec_o.rot    = instr_i[11:10];
    dec_o.unpred = hit && ((instr_i[15:12] == PC_REG) ||
                           (instr_i[3:0] == PC_REG) || sbz_bad);
  end
endmodule

// File: rtl/bsx_dec_compact.sv
`timescale 1ns/1ps
module bsx_dec_compact
  import bsx_pkg::*;
(
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  localparam logic [15:0] LONG_PFX = 16'hFA4F;
  localparam logic [9:0]  SHORT_OP = 10'b1011001001;

  logic is_long;
  logic long_hit;
  logic short_hit;

  assign is_long   = (instr_i[31:16] == LONG_PFX);
  // long prefix never falls back to the short form
  assign long_hit  = is_long && (instr_i[15:12] == 4'hF) && instr_i[7];
  assign short_hit = !is_long && (instr_i[15:6] == SHORT_OP);

  always_comb begin
    dec_o.hit = long_hit || short_hit;
    if (is_long) begin
      dec_o.rd     = instr_i[11:8];
      dec_o.rm     = instr_i[3:0];
      dec_o.rot    = instr_i[5:4];
      dec_o.unpred = long_hit && ((instr_i[11:8] == PC_REG) ||
                                  (instr_i[3:0] == PC_REG) || instr_i[6]);
    end else begin
      dec_o.rd     = {1'b0, instr_i[2:0]};
      dec_o.rm     = {1'b0, instr_i[5:3]};
      dec_o.rot    = '0;
      dec_o.unpred = 1'b0;
    end
  end
endmodule

// File: rtl/bsx_lane_ext.sv
`timescale 1ns/1ps
module bsx_lane_ext #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = XLEN / LANE_W,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic [XLEN-1:0]  data_i,
  input  logic [SEL_W-1:0] rot_i,
  output logic [XLEN-1:0]  result_o
);
  // rotate right by whole lanes then keep lane 0 == pick lane rot_i
  logic [LANE_W-1:0] lane [LANES];
  logic [LANE_W-1:0] pick;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = data_i[g*LANE_W +: LANE_W];
  end

  assign pick     = lane[rot_i];
  assign result_o = {{(XLEN-LANE_W){pick[LANE_W-1]}}, pick};
endmodule

// File: rtl/byte_sext_unit.sv
`timescale 1ns/1ps
module byte_sext_unit
  import bsx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic [31:0]      instr_i,
  input  logic             cond_pass_i,
  output logic [REG_W-1:0] rs_addr_o,
  input  logic [XLEN-1:0]  rs_data_i,
  output logic             match_o,
  output logic             unpred_o,
  output logic [REG_W-1:0] rd_o,
  output logic             we_o,
  output logic [XLEN-1:0]  result_o
);
  dec_t            dec_wide;
  dec_t            dec_cmp;
  dec_t            dec_sel;
  logic [XLEN-1:0] ext;
  logic            we_d;

  bsx_dec_wide    u_dec_wide (.instr_i(instr_i), .dec_o(dec_wide));
  bsx_dec_compact u_dec_cmp  (.instr_i(instr_i), .dec_o(dec_cmp));

  assign dec_sel   = mode_i ? dec_cmp : dec_wide;
  assign rs_addr_o = dec_sel.rm;

  bsx_lane_ext #(.XLEN(XLEN), .LANE_W(LANE_W)) u_ext (
    .data_i  (rs_data_i),
    .rot_i   (dec_sel.rot),
    .result_o(ext)
  );

  assign we_d = dec_sel.hit && cond_pass_i && !dec_sel.unpred;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_o  <= 1'b0;
      unpred_o <= 1'b0;
      rd_o     <= '0;
      we_o     <= 1'b0;
      result_o <= '0;
    end else begin
      match_o  <= dec_sel.hit;
      unpred_o <= dec_sel.unpred;
      rd_o     <= dec_sel.rd;
      we_o     <= we_d;
      result_o <= ext;
    end
  end

  a_r4_sign_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> (result_o[XLEN-1:LANE_W] == {(XLEN-LANE_W){result_o[LANE_W-1]}}));

  a_r5_reg15_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && rd_o == PC_REG) |-> (unpred_o && !we_o));

  a_r6_unpred_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unpred_o |-> (match_o && !we_o));

  a_r7_cond_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_sel.hit && !cond_pass_i) |=> (match_o && !we_o));

  a_r8_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_sel.hit && cond_pass_i && !dec_sel.unpred) |=> (we_o && rd_o == $past(dec_sel.rd)));
endmodule

// File: tb/byte_sext_unit_bench.sv
`timescale 1ns/1ps
module byte_sext_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] instr = '0;
  logic        cond = 1'b0;
  logic [3:0]  rs_addr;
  logic [31:0] rs_data;
  logic        match, unpred, we;
  logic [3:0]  rd;
  logic [31:0] res;

  logic [31:0] rf [16];
  assign rs_data = rf[rs_addr];

  always #2.5 clk = ~clk;

  byte_sext_unit u_byte_sext_unit (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .instr_i(instr),
    .cond_pass_i(cond), .rs_addr_o(rs_addr), .rs_data_i(rs_data),
    .match_o(match), .unpred_o(unpred), .rd_o(rd), .we_o(we), .result_o(res)
  );

  typedef struct {
    logic        m, u, w;
    logic [3:0]  rd;
    logic [31:0] res;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic logic [31:0] fx(logic [3:0] c, logic [3:0] d, logic [1:0] r,
                                     logic [1:0] z, logic [3:0] m);
    return {c, 8'h6A, 4'hF, d, r, z, 4'h7, m};
  endfunction

  function automatic logic [31:0] cl(logic [3:0] d, logic [1:0] r, logic z, logic [3:0] m);
    return {16'hFA4F, 4'hF, d, 1'b1, z, r, m};
  endfunction

  function automatic logic [31:0] cs(logic [2:0] m, logic [2:0] d);
    return {16'h0000, 10'b1011001001, m, d};
  endfunction

  function automatic exp_t model(bit md, logic [31:0] ins, bit cp, string tag);
    exp_t e;
    logic [3:0]  rm;
    logic [1:0]  rot;
    logic [63:0] dd;
    logic [7:0]  b;
    e.m = 0; e.u = 0; e.w = 0; e.rd = 0; e.res = 0; e.tag = tag;
    rm = 0; rot = 0;
    if (!md) begin
      if (ins[31:28] != 4'hF && ins[27:20] == 8'h6A && ins[19:16] == 4'hF && ins[7:4] == 4'h7) begin
        e.m = 1; e.rd = ins[15:12]; rm = ins[3:0]; rot = ins[11:10];
        e.u = (e.rd == 4'd15) || (rm == 4'd15) || (ins[9:8] != 2'b00);
      end
    end else if (ins[31:16] == 16'hFA4F) begin
      if (ins[15:12] == 4'hF && ins[7]) begin
        e.m = 1; e.rd = ins[11:8]; rm = ins[3:0]; rot = ins[5:4];
        e.u = (e.rd == 4'd15) || (rm == 4'd15) || ins[6];
      end
    end else if (ins[15:6] == 10'b1011001001) begin
      e.m = 1; e.rd = {1'b0, ins[2:0]}; rm = {1'b0, ins[5:3]};
    end
    dd    = {rf[rm], rf[rm]} >> (8 * rot);
    b     = dd[7:0];
    e.res = {{24{b[7]}}, b};
    e.w   = e.m && cp && !e.u;
    return e;
  endfunction

  task automatic drive(input bit md, input logic [31:0] ins, input bit cp,
                       input string tag, input int ri = -1, input logic [31:0] rv = '0);
    @(negedge clk);
    if (ri >= 0) rf[ri] = rv;
    mode = md; instr = ins; cond = cp;
    q.push_back(model(md, ins, cp, tag));
  endtask

  // monitor: one result per driven item, one clock later
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        n_chk++;
        if (match !== e.m || unpred !== e.u || we !== e.w ||
            (e.m && (rd !== e.rd || res !== e.res))) begin
          n_fail++;
          $display("FAIL %s: got m=%b u=%b w=%b rd=%0d res=%h exp m=%b u=%b w=%b rd=%0d res=%h",
                   e.tag, match, unpred, we, rd, res, e.m, e.u, e.w, e.rd, e.res);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++)
      rf[i] = {8'h80 + 8'(i), 8'h70 + 8'(i), 8'hF0 + 8'(i), 8'h10 + 8'(i)};
    repeat (3) @(negedge clk);
    // R9: reset state
    n_chk++;
    if ({match, unpred, we, rd, res} !== '0) begin
      n_fail++;
      $display("FAIL R9 reset: got m=%b u=%b w=%b rd=%0d res=%h exp all zero",
               match, unpred, we, rd, res);
    end
    rst_n = 1'b1;

    // R1, R4: each rotate lane of the fixed form
    drive(0, fx(4'hE, 4'd2, 2'd0, 2'd0, 4'd3), 1, "R1 R4 rot0");
    drive(0, fx(4'hE, 4'd2, 2'd1, 2'd0, 4'd3), 1, "R4 rot8");
    drive(0, fx(4'h0, 4'd4, 2'd2, 2'd0, 4'd3), 1, "R4 rot16");
    drive(0, fx(4'hA, 4'd4, 2'd3, 2'd0, 4'd3), 1, "R4 rot24");
    drive(0, fx(4'hF, 4'd2, 2'd0, 2'd0, 4'd3), 1, "R1 cond field 1111");
    // R5: register 15 and 13
    drive(0, fx(4'hE, 4'd15, 2'd0, 2'd0, 4'd3), 1, "R5 wide rd15");
    drive(0, fx(4'hE, 4'd1, 2'd1, 2'd0, 4'd15), 1, "R5 wide rm15");
    drive(0, fx(4'hE, 4'd13, 2'd1, 2'd0, 4'd13), 1, "R5 wide r13 legal");
    // R6: should-be-zero
    drive(0, fx(4'hE, 4'd5, 2'd0, 2'd1, 4'd6), 1, "R6 wide sbz");
    // R7: condition fail, then combined with register 15
    drive(0, fx(4'hE, 4'd5, 2'd2, 2'd0, 4'd6), 0, "R7 cond fail");
    drive(0, fx(4'hE, 4'd15, 2'd2, 2'd0, 4'd6), 0, "R5 R7 rd15 and cond fail");
    // R2: short compact form
    drive(1, cs(3'd5, 3'd6), 1, "R2 short");
    drive(1, cs(3'd7, 3'd0), 1, "R2 short neg", 7, 32'h0000_0080);
    // R3: long compact form
    drive(1, cl(4'd13, 2'd2, 1'b0, 4'd13), 1, "R3 R5 long r13");
    drive(1, cl(4'd9, 2'd1, 1'b0, 4'd11), 1, "R3 long rot8");
    drive(1, cl(4'd9, 2'd0, 1'b0, 4'd15), 1, "R5 long rm15");
    drive(1, cl(4'd9, 2'd3, 1'b1, 4'd2), 1, "R6 long sbz");
    // R11: mode exclusivity and no fallback
    drive(1, cl(4'd9, 2'd3, 1'b0, 4'd2) & ~32'h80, 1, "R11 long bad second half");
    drive(1, fx(4'hE, 4'd2, 2'd0, 2'd0, 4'd3), 1, "R11 wide word in compact mode");
    drive(0, cs(3'd5, 3'd6), 1, "R11 short in fixed mode");
    // R10: garbage
    drive(0, 32'h1234_5678, 1, "R10 garbage");
    drive(1, 32'hFFFF_FFFF, 1, "R10 garbage compact");
    // R8: data independence, back to back with changing data
    drive(0, fx(4'hE, 4'd8, 2'd1, 2'd0, 4'd9), 1, "R8 data A", 9, 32'h0000_7F00);
    drive(0, fx(4'hE, 4'd8, 2'd1, 2'd0, 4'd9), 1, "R8 data B", 9, 32'hFFFF_80FF);
    drive(0, fx(4'hE, 4'd8, 2'd1, 2'd0, 4'd9), 1, "R8 data C", 9, 32'h0000_0000);
    drive(0, 32'h0, 0, "R10 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule